// File: doc/BRIEF.md
# Isochronous Buffer Address Walker

This block turns one isochronous transaction slot of a USB host controller into a series of 32-bit word requests to memory. Software-side logic first writes seven page words into the block. Bits [31:12] of each page word are a 4 KB-aligned page base. The low 12 bits of the first two words carry endpoint fields. A slot is then started with a page select, a 12-bit byte offset, a byte length and an interrupt-on-complete flag. The block joins the selected page base to the offset, then walks through the buffer one word at a time. Byte enables trim the first and last words. Whenever the offset runs past the end of a 4 KB page, the walk moves to the next listed page word, so the pages of a logically contiguous buffer may lie anywhere in physical memory.

For IN endpoints, the block adds up the bytes reported as received and flags babble as soon as the total goes above the endpoint's maximum packet size. When a slot that asked for an interrupt completes, the request is held and only presented on the next interrupt-threshold tick. Descriptor fetch, packet protocol and scheduling lie outside the block.

The controller is a four-state machine: `S_IDLE`, `S_CHECK`, `S_MOVE` and `S_FINISH`. Its transitions are:
- `S_IDLE` to `S_CHECK` on an accepted start.
- `S_CHECK` back to `S_IDLE` on an illegal page select or maximum packet size.
- `S_CHECK` to `S_FINISH` for a zero length.
- `S_CHECK` to `S_MOVE` otherwise.
- `S_MOVE` to `S_FINISH` on the handshake that moves the last byte, or on page overflow.
- `S_FINISH` to `S_IDLE` always.

Top module: `iso_buf_walker`

## Requirements
- R1: A page word written with `page_wr_en` at index 0..6 is stored. The first request of a slot has address {page base [31:12] selected by `slot_page`, `slot_offset[11:2]`, 2'b00}.
- R2: Byte lane i of `mem_req_be` covers address bits [1:0] = i. For a word where a = offset[1:0], the block moves n = min(4 - a, bytes remaining) bytes, and the enabled lanes are a through a+n-1.
- R3: A `slot_page` value of 7 sets `err_page_sel`. It issues no memory request and gives no `done`, and the block returns to idle.
- R4: A maximum packet size above 1024 sets `err_max_pkt`, with the same refusal as R3. A value of exactly 1024 is accepted.
- R5: When a word carries the offset past 4095, the offset wraps to the remaining low bits. If bytes remain, the page index advances by one.
- R6: When a page crossing on page 6 leaves bytes still to move, `err_page_ovf` is set, no further request is issued, and `done` reports the bytes moved so far.
- R7: `done` is a one-cycle pulse. `done_bytes` gives the bytes moved, and `done_page` gives the page index of the last byte moved, or the selected page for a zero-length slot.
- R8: For IN endpoints (page word 1 bit 11 = 1), bytes received since the start are summed from `rx_valid`/`rx_bytes`, and a sum above the maximum packet size sets `err_babble`. For OUT endpoints, received bytes have no effect.
- R9: A `done` with `slot_ioc` set leaves an interrupt pending. `irq` pulses for one cycle in the cycle after the next `thresh_tick`, and a tick with nothing pending gives no pulse.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the address and byte enables hold.
- R11: Error flags stay set until the next accepted start, which clears them. A start while busy is ignored.
- R12: `ep_dev_addr` = page word 0 bits [6:0], `ep_num` = word 0 bits [11:8], `ep_dir_in` = word 1 bit 11, and `ep_max_pkt` = word 1 bits [10:0].
- R13: After reset, the block is idle, with no request, no `done`, no `irq` and all error flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_wr_en | input | 1 | Write one page word |
| page_wr_idx | input | 3 | Page word index 0..6 |
| page_wr_data | input | 32 | Page word value |
| slot_start | input | 1 | Start the slot when idle |
| slot_page | input | 3 | Page select of the slot |
| slot_offset | input | 12 | Byte offset within the selected page |
| slot_len | input | 15 | Bytes to move |
| slot_ioc | input | 1 | Interrupt on complete |
| rx_valid | input | 1 | Received-byte report valid |
| rx_bytes | input | 3 | Bytes received in this report (0..4) |
| thresh_tick | input | 1 | Interrupt-threshold pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_req_be | output | 4 | Byte enables |
| ep_dev_addr | output | 7 | Device address field |
| ep_num | output | 4 | Endpoint number field |
| ep_dir_in | output | 1 | Direction, 1 = IN |
| ep_max_pkt | output | 11 | Maximum packet size field |
| busy | output | 1 | Not idle |
| done | output | 1 | Slot completion pulse |
| done_bytes | output | 15 | Bytes moved |
| done_page | output | 3 | Final page index |
| err_page_sel | output | 1 | Illegal page select |
| err_max_pkt | output | 1 | Illegal maximum packet size |
| err_page_ovf | output | 1 | Walked past the last page |
| err_babble | output | 1 | IN data above maximum packet size |
| irq | output | 1 | Interrupt request pulse |

## Verification
Any corruption of the offset, page index or remaining count appears at the ports within one request. The bench model predicts every address and byte-enable pair and compares each handshake, so a wrong page hop or a wrong lane mask is reported on the beat where it first differs. A stale remaining count shows up as an extra request with no prediction, or as a short `done_bytes`, within one cycle of the end of the slot. A pending-interrupt or babble register that is wrong shows up on the cycle after the tick or the received-byte report that should have changed it.

// File: rtl/iso_walk_pkg.sv
package iso_walk_pkg;

    localparam int PTR_W  = 20;
    localparam int OFF_W  = 12;
    localparam int WORD_W = 32;
    localparam int MPS_W  = 11;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_MOVE,
        S_FINISH
    } walk_state_t;

    function automatic logic [3:0] lane_mask(input logic [1:0] first, input logic [2:0] count);
        logic [3:0] m;
        m = 4'b0000;
        for (int i = 0; i < 4; i++) begin
            if (i >= int'(first) && i < int'(first) + int'(count)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/iso_page_table.sv
module iso_page_table #(
    parameter int NUM_PAGES = 7,
    parameter int PG_W      = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [PG_W-1:0]                  wr_idx,
    input  logic [iso_walk_pkg::WORD_W-1:0]  wr_data,
    input  logic [PG_W-1:0]                  rd_idx,
    output logic [iso_walk_pkg::PTR_W-1:0]   rd_base,
    output logic [6:0]                       dev_addr,
    output logic [3:0]                       ep_num,
    output logic                             ep_in,
    output logic [iso_walk_pkg::MPS_W-1:0]   max_pkt
);
    import iso_walk_pkg::*;

    logic [WORD_W-1:0] words [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en && wr_idx == PG_W'(g)) begin
                words[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_base = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (rd_idx == PG_W'(i)) begin
                rd_base = words[i][WORD_W-1:OFF_W];
            end
        end
    end

    assign dev_addr = words[0][6:0];
    assign ep_num   = words[0][11:8];
    assign ep_in    = words[1][11];
    assign max_pkt  = words[1][MPS_W-1:0];

endmodule

// File: rtl/iso_beat_calc.sv
module iso_beat_calc #(
    parameter int LEN_W = 15
) (
    input  logic [iso_walk_pkg::OFF_W-1:0] offset,
    input  logic [LEN_W-1:0]               remain,
    output logic [3:0]                     be,
    output logic [2:0]                     nbytes,
    output logic [iso_walk_pkg::OFF_W-1:0] offset_next,
    output logic                           carry
);
    import iso_walk_pkg::*;

    logic [2:0]     room;
    logic [OFF_W:0] sum;

    always_comb begin
        room        = 3'd4 - {1'b0, offset[1:0]};
        nbytes      = (remain < {{(LEN_W-3){1'b0}}, room}) ? remain[2:0] : room;
        be          = lane_mask(offset[1:0], nbytes);
        sum         = {1'b0, offset} + {{(OFF_W-2){1'b0}}, nbytes};
        offset_next = sum[OFF_W-1:0];
        carry       = sum[OFF_W];
    end

endmodule

// File: rtl/iso_rx_babble.sv
module iso_rx_babble #(
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           count_en,
    input  logic                           rx_valid,
    input  logic [2:0]                     rx_bytes,
    input  logic [iso_walk_pkg::MPS_W-1:0] max_pkt,
    output logic                           babble
);
    import iso_walk_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic             take;

    always_comb begin
        take = count_en && rx_valid;
        sum  = {1'b0, cnt_q} + {{(CNT_W-2){1'b0}}, rx_bytes};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            babble <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            babble <= 1'b0;
        end else if (take) begin
            cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            if (sum > {{(CNT_W+1-MPS_W){1'b0}}, max_pkt}) begin
                babble <= 1'b1;
            end
        end
    end

    p_babble_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        babble && !clr |=> babble);

    p_babble_needs_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(babble) |-> $past(count_en) && $past(rx_valid));

endmodule

// File: rtl/iso_irq_hold.sv
module iso_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic irq
);
    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= tick && pending_q;
            if (arm) begin
                pending_q <= 1'b1;
            end else if (tick) begin
                pending_q <= 1'b0;
            end
        end
    end

    p_irq_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !arm |=> !irq || $past(arm));

endmodule

// File: rtl/iso_buf_walker.sv
module iso_buf_walker #(
    parameter int NUM_PAGES = 7,
    parameter int LEN_W     = 15,
    parameter int MPS_MAX   = 1024,
    parameter int PG_W      = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             page_wr_en,
    input  logic [PG_W-1:0]  page_wr_idx,
    input  logic [31:0]      page_wr_data,
    input  logic             slot_start,
    input  logic [PG_W-1:0]  slot_page,
    input  logic [11:0]      slot_offset,
    input  logic [LEN_W-1:0] slot_len,
    input  logic             slot_ioc,
    input  logic             rx_valid,
    input  logic [2:0]       rx_bytes,
    input  logic             thresh_tick,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [31:0]      mem_req_addr,
    output logic [3:0]       mem_req_be,
    output logic [6:0]       ep_dev_addr,
    output logic [3:0]       ep_num,
    output logic             ep_dir_in,
    output logic [10:0]      ep_max_pkt,
    output logic             busy,
    output logic             done,
    output logic [LEN_W-1:0] done_bytes,
    output logic [PG_W-1:0]  done_page,
    output logic             err_page_sel,
    output logic             err_max_pkt,
    output logic             err_page_ovf,
    output logic             err_babble,
    output logic             irq
);
    import iso_walk_pkg::*;

    localparam logic [PG_W-1:0]  LAST_PAGE = PG_W'(NUM_PAGES - 1);
    localparam logic [MPS_W-1:0] MPS_LIM   = MPS_W'(MPS_MAX);

    walk_state_t state_q, state_d;

    logic [PG_W-1:0]  page_q;
    logic [OFF_W-1:0] off_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] moved_q;
    logic             ioc_q;
    logic             err_pg_q, err_mps_q, err_ovf_q;

    logic [PTR_W-1:0] base;
    logic [3:0]       be_c;
    logic [2:0]       nbytes;
    logic [OFF_W-1:0] off_next;
    logic             carry;
    logic [LEN_W-1:0] remain_after;
    logic             start_acc, hs, bad_pg, bad_mps, ovf_hit, last_beat, hop;

    iso_page_table #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (page_wr_en),
        .wr_idx   (page_wr_idx),
        .wr_data  (page_wr_data),
        .rd_idx   (page_q),
        .rd_base  (base),
        .dev_addr (ep_dev_addr),
        .ep_num   (ep_num),
        .ep_in    (ep_dir_in),
        .max_pkt  (ep_max_pkt)
    );

    iso_beat_calc #(.LEN_W(LEN_W)) u_beat (
        .offset      (off_q),
        .remain      (remain_q),
        .be          (be_c),
        .nbytes      (nbytes),
        .offset_next (off_next),
        .carry       (carry)
    );

    iso_rx_babble u_babble (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_acc),
        .count_en (busy && ep_dir_in),
        .rx_valid (rx_valid),
        .rx_bytes (rx_bytes),
        .max_pkt  (ep_max_pkt),
        .babble   (err_babble)
    );

    iso_irq_hold u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (done && ioc_q),
        .tick  (thresh_tick),
        .irq   (irq)
    );

    always_comb begin
        start_acc    = slot_start && (state_q == S_IDLE);
        hs           = (state_q == S_MOVE) && mem_req_ready;
        bad_pg       = page_q > LAST_PAGE;
        bad_mps      = ep_max_pkt > MPS_LIM;
        remain_after = remain_q - {{(LEN_W-3){1'b0}}, nbytes};
        last_beat    = remain_after == '0;
        hop          = carry && !last_beat;
        ovf_hit      = hop && (page_q == LAST_PAGE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_acc) state_d = S_CHECK;
            S_CHECK: begin
                if (bad_pg || bad_mps)   state_d = S_IDLE;
                else if (remain_q == '0) state_d = S_FINISH;
                else                     state_d = S_MOVE;
            end
            S_MOVE:   if (hs && (last_beat || ovf_hit)) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            off_q     <= '0;
            remain_q  <= '0;
            moved_q   <= '0;
            ioc_q     <= 1'b0;
            err_pg_q  <= 1'b0;
            err_mps_q <= 1'b0;
            err_ovf_q <= 1'b0;
        end else if (start_acc) begin
            page_q    <= slot_page;
            off_q     <= slot_offset;
            remain_q  <= slot_len;
            moved_q   <= '0;
            ioc_q     <= slot_ioc;
            err_pg_q  <= 1'b0;
            err_mps_q <= 1'b0;
            err_ovf_q <= 1'b0;
        end else if (state_q == S_CHECK) begin
            err_pg_q  <= bad_pg;
            err_mps_q <= bad_mps;
        end else if (hs) begin
            remain_q <= remain_after;
            moved_q  <= moved_q + {{(LEN_W-3){1'b0}}, nbytes};
            off_q    <= off_next;
            if (ovf_hit)   err_ovf_q <= 1'b1;
            else if (hop)  page_q    <= page_q + 1'b1;
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        unique case (state_q)
            S_IDLE:   busy          = 1'b0;
            S_CHECK:  ;
            S_MOVE:   mem_req_valid = 1'b1;
            S_FINISH: done          = 1'b1;
            default:  busy          = 1'b0;
        endcase
        mem_req_addr = {base, off_q[OFF_W-1:2], 2'b00};
        mem_req_be   = be_c;
        done_bytes   = moved_q;
        done_page    = page_q;
        err_page_sel = err_pg_q;
        err_max_pkt  = err_mps_q;
        err_page_ovf = err_ovf_q;
    end

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be));

    p_no_req_bad_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_page_sel |-> !mem_req_valid && !done);

    p_refuse_mps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_max_pkt) |-> !busy && !mem_req_valid);

    p_be_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_be != 4'b0000);

    p_page_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> page_q <= LAST_PAGE);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_ovf_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_page_ovf) |-> done);

endmodule

// File: tb/tb_iso_buf_walker.sv
module tb_iso_buf_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_wr_en = 1'b0;
    logic [2:0]  page_wr_idx = '0;
    logic [31:0] page_wr_data = '0;
    logic        slot_start = 1'b0;
    logic [2:0]  slot_page = '0;
    logic [11:0] slot_offset = '0;
    logic [14:0] slot_len = '0;
    logic        slot_ioc = 1'b0;
    logic        rx_valid = 1'b0;
    logic [2:0]  rx_bytes = '0;
    logic        thresh_tick = 1'b0;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic [3:0]  mem_req_be;
    logic [6:0]  ep_dev_addr;
    logic [3:0]  ep_num;
    logic        ep_dir_in;
    logic [10:0] ep_max_pkt;
    logic        busy, done;
    logic [14:0] done_bytes;
    logic [2:0]  done_page;
    logic        err_page_sel, err_max_pkt, err_page_ovf, err_babble, irq;

    iso_buf_walker dut (
        .clk(clk), .rst_n(rst_n),
        .page_wr_en(page_wr_en), .page_wr_idx(page_wr_idx), .page_wr_data(page_wr_data),
        .slot_start(slot_start), .slot_page(slot_page), .slot_offset(slot_offset),
        .slot_len(slot_len), .slot_ioc(slot_ioc),
        .rx_valid(rx_valid), .rx_bytes(rx_bytes), .thresh_tick(thresh_tick),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
        .ep_dev_addr(ep_dev_addr), .ep_num(ep_num), .ep_dir_in(ep_dir_in), .ep_max_pkt(ep_max_pkt),
        .busy(busy), .done(done), .done_bytes(done_bytes), .done_page(done_page),
        .err_page_sel(err_page_sel), .err_max_pkt(err_max_pkt), .err_page_ovf(err_page_ovf),
        .err_babble(err_babble), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    logic [19:0] m_base [7];
    logic        m_in;
    int          m_mps;
    logic [31:0] q_addr [$];
    logic [3:0]  q_be   [$];
    int          e_bytes, e_page;
    bit          e_ovf;
    bit          hold = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          saw_done;
    int          got_bytes, got_page;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural model of the word walk
    task automatic predict(input int pg, input int off, input int len);
        int p, o, rem, a, n;
        p = pg; o = off; rem = len; e_bytes = 0; e_ovf = 0;
        while (rem > 0) begin
            a = o % 4;
            n = (4 - a < rem) ? 4 - a : rem;
            q_addr.push_back({m_base[p], 12'(o & 'hFFC)});
            q_be.push_back(4'(((1 << n) - 1) << a));
            rem -= n; e_bytes += n; o += n;
            if (o >= 4096) begin
                o -= 4096;
                if (rem > 0) begin
                    if (p == 6) begin e_ovf = 1; break; end
                    p++;
                end
            end
        end
        e_page = p;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = hold ? 1'b0 : (lfsr[0] | lfsr[3]);
        end
    end

    // per-clock comparison of every request against the model queue (R1, R2, R5, R10)
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && mem_req_valid) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R3/R11", "unexpected request addr", mem_req_addr, 0);
                end else if (mem_req_ready) begin
                    chk(mem_req_addr == q_addr[0] && mem_req_be == q_be[0], "R1/R2/R5",
                        "request addr,be", {mem_req_addr, mem_req_be}, {q_addr[0], q_be[0]});
                    void'(q_addr.pop_front());
                    void'(q_be.pop_front());
                end
            end
        end
    end

    task automatic write_page(input int idx, input logic [31:0] w);
        @(negedge clk);
        page_wr_en = 1; page_wr_idx = 3'(idx); page_wr_data = w;
        @(negedge clk);
        page_wr_en = 0;
        if (idx == 1) begin m_in = w[11]; m_mps = int'(w[10:0]); end
    endtask

    task automatic kick(input int pg, input int off, input int len, input bit ioc);
        if (pg <= 6 && m_mps <= 1024) predict(pg, off, len);
        @(negedge clk);
        slot_start = 1; slot_page = 3'(pg); slot_offset = 12'(off);
        slot_len = 15'(len); slot_ioc = ioc;
        @(negedge clk);
        slot_start = 0;
    endtask

    task automatic wait_idle();
        saw_done = 0;
        for (int k = 0; k < 40000; k++) begin
            #5;
            if (done) begin saw_done = 1; got_bytes = done_bytes; got_page = done_page; end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_end(input string req);
        chk(saw_done == 1, req, "done seen", saw_done, 1);
        chk(got_bytes == e_bytes && got_page == e_page, req, "done bytes,page",
            {got_bytes, got_page}, {e_bytes, e_page});
        chk(err_page_ovf == e_ovf, "R6", "overflow flag", err_page_ovf, e_ovf);
        chk(q_addr.size() == 0, req, "requests left", q_addr.size(), 0);
    endtask

    task automatic run(input int pg, input int off, input int len, input bit ioc, input string req);
        kick(pg, off, len, ioc);
        wait_idle();
        expect_end(req);
    endtask

    initial begin
        m_in = 0; m_mps = 0;
        repeat (3) @(negedge clk);
        #5;
        chk(!busy && !mem_req_valid && !done && !irq, "R13", "idle outputs",
            {busy, mem_req_valid, done, irq}, 0);
        chk({err_page_sel, err_max_pkt, err_page_ovf, err_babble} == 0, "R13", "error flags",
            {err_page_sel, err_max_pkt, err_page_ovf, err_babble}, 0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < 7; i++) m_base[i] = 20'h3C000 ^ 20'(i * 'h1357 + 3);
        write_page(0, {m_base[0], 4'h5, 1'b0, 7'h2B});
        write_page(1, {m_base[1], 1'b0, 11'd512});
        for (int i = 2; i < 7; i++) write_page(i, {m_base[i], 12'h000});
        #5;
        chk(ep_dev_addr == 7'h2B && ep_num == 4'h5 && !ep_dir_in && ep_max_pkt == 11'd512,
            "R12", "endpoint fields", {ep_dev_addr, ep_num, ep_dir_in, ep_max_pkt},
            {7'h2B, 4'h5, 1'b0, 11'd512});

        run(1, 'h010, 16, 0, "R1");
        run(3, 'h123, 7, 0, "R2");
        run(2, 'hFFE, 10, 0, "R5");
        run(6, 'hF80, 300, 0, "R6");
        run(0, 'hFFF, 24576, 0, "R7");
        run(4, 'h100, 0, 0, "R7");

        // R3: illegal page select, then R11: next start clears it
        kick(7, 0, 8, 0);
        wait_idle();
        chk(err_page_sel && !saw_done, "R3", "page select error, no done", {err_page_sel, saw_done}, 2'b10);
        run(5, 'h004, 4, 0, "R11");
        chk(!err_page_sel, "R11", "error cleared by start", err_page_sel, 0);

        // R4: maximum packet size boundary
        write_page(1, {m_base[1], 1'b0, 11'd1024});
        run(1, 'h000, 8, 0, "R4");
        write_page(1, {m_base[1], 1'b0, 11'd1025});
        kick(1, 0, 8, 0);
        wait_idle();
        chk(err_max_pkt && !saw_done, "R4", "max packet error, no done", {err_max_pkt, saw_done}, 2'b10);

        // R8: babble on IN
        write_page(1, {m_base[1], 1'b1, 11'd8});
        hold = 1;
        kick(1, 'h020, 8, 0);
        @(negedge clk); rx_valid = 1; rx_bytes = 4;
        @(negedge clk); rx_bytes = 4;
        @(negedge clk); rx_valid = 0;
        #5 chk(!err_babble, "R8", "no babble at limit", err_babble, 0);
        @(negedge clk); rx_valid = 1; rx_bytes = 1;
        @(negedge clk); rx_valid = 0;
        #5 chk(err_babble, "R8", "babble above limit", err_babble, 1);
        hold = 0;
        wait_idle();
        expect_end("R8");
        chk(err_babble, "R8", "babble held to end", err_babble, 1);

        // R8: OUT ignores received bytes
        write_page(1, {m_base[1], 1'b0, 11'd8});
        hold = 1;
        kick(2, 'h040, 4, 0);
        for (int k = 0; k < 4; k++) begin @(negedge clk); rx_valid = 1; rx_bytes = 4; end
        @(negedge clk); rx_valid = 0;
        #5 chk(!err_babble, "R8", "OUT ignores rx", err_babble, 0);
        hold = 0;
        wait_idle();
        expect_end("R8");

        // R11: start while busy ignored
        hold = 1;
        kick(1, 'h000, 8, 0);
        @(negedge clk); slot_start = 1; slot_page = 3'd5; slot_len = 15'd40;
        @(negedge clk); slot_start = 0;
        hold = 0;
        wait_idle();
        expect_end("R11");

        // R9: interrupt held until tick
        @(negedge clk); thresh_tick = 1;
        @(negedge clk); thresh_tick = 0;
        #5 chk(!irq, "R9", "tick with nothing pending", irq, 0);
        run(3, 'h200, 12, 1, "R9");
        repeat (3) @(negedge clk);
        #5 chk(!irq, "R9", "irq waits for tick", irq, 0);
        @(negedge clk); thresh_tick = 1;
        @(negedge clk); thresh_tick = 0;
        #5 chk(irq, "R9", "irq after tick", irq, 1);
        @(negedge clk);
        #5 chk(!irq, "R9", "irq one cycle", irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule